// File: doc/BRIEF.md
# Three-Phase 8-Bit Accumulator Processor

This block is a small accumulator processor that runs a handful of byte-coded instructions out of a program ROM. Every instruction takes exactly three clock cycles: a fetch cycle, a decode cycle and an execute cycle. The current phase and the held opcode produce a separate write enable for each state element: the opcode register, the eight working registers, the operand holding register, the program counter, the accumulator and the carry flag.

The ROM is read through an 8-bit address output and an 8-bit data input. The ROM is read combinationally within the same cycle. In the fetch and execute cycles the address is the program counter. In the decode cycle the address is the program counter plus one, so that the second byte of a two-byte instruction is present while that instruction is being decoded.

The accumulator, the program counter and all eight working registers are brought out for observation. The supported operations are:

- an immediate load of the accumulator;
- a clear or set of one chosen accumulator bit;
- a copy of the accumulator into a working register;
- an add of a working register plus carry;
- a nibble swap;
- a short relative jump.

Top module: `mini_acc_cpu`

## Requirements
- R1: After reset the phase runs fetch, decode, execute and then repeats, so each instruction occupies exactly three clock cycles.
- R2: The opcode register loads the ROM byte only in the fetch cycle and holds it through decode and execute.
- R3: For the two-byte opcodes 0x74 (load immediate), 0xC2 and 0xD2 (bit edit), the PC advances by one in decode and again in execute, and the second byte is captured into the operand register in decode. For 0x74 the accumulator takes that byte in execute.
- R4: The bit-edit opcodes match the pattern 110X0010. Operand bits [2:0] pick one accumulator bit through a one-hot decode (0 picks bit 0, 7 picks bit 7). Opcode bit 4 equal to 0 clears that bit and equal to 1 sets it. Operand bits [7:3] are ignored, and all other accumulator bits keep their value.
- R5: The accumulator changes only at the end of an execute cycle. Any opcode outside the supported set leaves the accumulator and the registers unchanged and advances the PC by one.
- R6: Opcodes 0xF8 to 0xFF copy the accumulator into the working register numbered by opcode bits [2:0].
- R7: Opcodes 0x38 to 0x3F add the working register numbered by opcode bits [2:0], plus the carry flag, into the accumulator. The carry flag takes the carry out of bit 7.
- R8: Opcode 0xC4 exchanges the upper and lower four bits of the accumulator.
- R9: Opcode 0x80 with an offset byte jumps to the address after the two-byte instruction plus the sign-extended offset. An offset of 0xFE therefore jumps back to the jump itself.
- R10: A synchronous active-high reset clears the accumulator, PC, carry flag, working registers and phase. After reset, execution starts with a fetch at address 0.
- R11: Single-byte opcodes advance the PC by one, in decode only, and do not load the operand register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 8 | Program ROM byte address |
| rom_data | input | 8 | Program ROM byte at rom_addr |
| dbg_acc | output | 8 | Accumulator value |
| dbg_pc | output | 8 | Program counter value |
| dbg_regs | output | 64 | Working registers; register n occupies bits [8n+7:8n] |

## Verification
The bench clears every accumulator bit one at a time, and separately sets every bit one at a time. A decoder with a wrong bit order, or one that flips the sense of opcode bit 4, therefore leaves visibly wrong accumulator values. An operand byte with high bits set would make a decoder that uses the full byte miss the intended bit, and a repeated set of an already-set bit would expose a toggle in place of a set.

Two consecutive adds are run: the first produces a carry and the second consumes it. A design that drops the carry, or never clears it, gives a result off by one.

Forward and self-targeting jumps, and opcodes outside the set, check that the PC arithmetic uses the address after the instruction. A design that gets this wrong lands on the skipped bytes or runs away from the self loop.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DW   = 8;
    localparam int NREG = 8;
    localparam int RSEL = $clog2(NREG);

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

    localparam byte_t OP_LDI    = 8'h74;
    localparam byte_t OP_JREL   = 8'h80;
    localparam byte_t OP_SWAP   = 8'hC4;
    localparam byte_t BIT_MASK  = 8'hEF;
    localparam byte_t BIT_MATCH = 8'hC2;

    typedef struct packed {
        logic ir;
        logic rf;
        logic aux;
        logic pc;
        logic acc;
        logic cy;
        logic jump;
    } wen_t;

    function automatic logic is_bitop(byte_t op);
        return (op & BIT_MASK) == BIT_MATCH;
    endfunction

    function automatic logic is_mov_rn(byte_t op);
        return op[DW-1:RSEL] == 5'b11111;
    endfunction

    function automatic logic is_addc(byte_t op);
        return op[DW-1:RSEL] == 5'b00111;
    endfunction

    function automatic logic is_two_byte(byte_t op);
        return (op == OP_LDI) || (op == OP_JREL) || is_bitop(op);
    endfunction

    function automatic logic writes_acc(byte_t op);
        return (op == OP_LDI) || (op == OP_SWAP) || is_bitop(op) || is_addc(op);
    endfunction

endpackage

// File: rtl/acc_phase_seq.sv
module acc_phase_seq
    import acc_cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
        end else begin
            unique case (phase)
                PH_FETCH:  phase <= PH_DECODE;
                PH_DECODE: phase <= PH_EXEC;
                default:   phase <= PH_FETCH;
            endcase
        end
    end

    assert_fetch_to_decode_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (phase == PH_DECODE));
    assert_decode_to_exec_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DECODE) |=> (phase == PH_EXEC));
    assert_exec_to_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC) |=> (phase == PH_FETCH));
    assert_reset_phase_R10: assert property (@(posedge clk)
        rst |=> (phase == PH_FETCH));

endmodule

// File: rtl/acc_ctl.sv
module acc_ctl
    import acc_cpu_pkg::*;
(
    input  phase_e phase,
    input  byte_t  op,
    output wen_t   wen
);

    always_comb begin
        wen = '0;
        unique case (phase)
            PH_FETCH: begin
                wen.ir = 1'b1;
            end
            PH_DECODE: begin
                wen.pc  = 1'b1;
                wen.aux = is_two_byte(op);
            end
            default: begin
                wen.acc  = writes_acc(op);
                wen.rf   = is_mov_rn(op);
                wen.cy   = is_addc(op);
                wen.pc   = is_two_byte(op);
                wen.jump = (op == OP_JREL);
            end
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_cpu_pkg::*;
(
    input  byte_t op,
    input  byte_t aux,
    input  byte_t acc,
    input  byte_t rn,
    input  logic  cy_in,
    output byte_t res,
    output logic  cy_out
);

    byte_t        edited;
    logic [DW:0]  sum;

    for (genvar i = 0; i < DW; i++) begin : g_bitmux
        assign edited[i] = (aux[RSEL-1:0] == RSEL'(i)) ? op[4] : acc[i];
    end

    assign sum = {1'b0, acc} + {1'b0, rn} + (DW+1)'(cy_in);

    always_comb begin
        res    = acc;
        cy_out = cy_in;
        if (op == OP_LDI) begin
            res = aux;
        end else if (is_bitop(op)) begin
            res = edited;
        end else if (is_addc(op)) begin
            res    = sum[DW-1:0];
            cy_out = sum[DW];
        end else if (op == OP_SWAP) begin
            res = {acc[DW/2-1:0], acc[DW-1:DW/2]};
        end
    end

endmodule

// File: rtl/mini_acc_cpu.sv
module mini_acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [DW-1:0]      rom_addr,
    input  logic [DW-1:0]      rom_data,
    output logic [DW-1:0]      dbg_acc,
    output logic [DW-1:0]      dbg_pc,
    output logic [NREG*DW-1:0] dbg_regs
);

    phase_e phase;
    wen_t   wen;
    byte_t  ir_q, aux_q, acc_q, pc_q;
    logic   cy_q;
    byte_t  rf_q [NREG];
    byte_t  rn, alu_res, pc_inc, pc_next;
    logic   alu_cy;

    acc_phase_seq u_seq (.clk(clk), .rst(rst), .phase(phase));

    acc_ctl u_ctl (.phase(phase), .op(ir_q), .wen(wen));

    assign rn = rf_q[ir_q[RSEL-1:0]];

    acc_alu u_alu (
        .op(ir_q), .aux(aux_q), .acc(acc_q), .rn(rn), .cy_in(cy_q),
        .res(alu_res), .cy_out(alu_cy)
    );

    assign pc_inc   = pc_q + byte_t'(1);
    assign pc_next  = wen.jump ? byte_t'(pc_inc + aux_q) : pc_inc;
    assign rom_addr = (phase == PH_DECODE) ? pc_inc : pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q  <= '0;
            aux_q <= '0;
            acc_q <= '0;
            pc_q  <= '0;
            cy_q  <= 1'b0;
        end else begin
            if (wen.ir)  ir_q  <= rom_data;
            if (wen.aux) aux_q <= rom_data;
            if (wen.pc)  pc_q  <= pc_next;
            if (wen.acc) acc_q <= alu_res;
            if (wen.cy)  cy_q  <= alu_cy;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                rf_q[i] <= '0;
            end else if (wen.rf && ir_q[RSEL-1:0] == RSEL'(i)) begin
                rf_q[i] <= acc_q;
            end
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_dbg
        assign dbg_regs[i*DW +: DW] = rf_q[i];
    end

    assign dbg_acc = acc_q;
    assign dbg_pc  = pc_q;

    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_FETCH) |=> $stable(ir_q));
    assert_acc_exec_only_R5: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_EXEC) |=> $stable(acc_q));
    assert_regs_exec_only_R6: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_EXEC) |=> $stable(dbg_regs));
    assert_pc_fetch_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> $stable(pc_q));
    assert_one_bit_edit_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && is_bitop(ir_q)) |=> ($countones(acc_q ^ $past(acc_q)) <= 1));
    assert_short_op_pc_R11: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && !is_two_byte(ir_q)) |=> $stable(pc_q));
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && pc_q == '0 && dbg_regs == '0));

endmodule

// File: tb/mini_acc_cpu_test.sv
module mini_acc_cpu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rom_addr, rom_data;
    logic [7:0]  dbg_acc, dbg_pc;
    logic [63:0] dbg_regs;

    logic [7:0]  rom [256];
    assign rom_data = rom[rom_addr];

    always #4 clk = ~clk;

    mini_acc_cpu uut (
        .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
        .dbg_acc(dbg_acc), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
    );

    typedef struct {
        logic [7:0]  acc;
        logic [7:0]  pc;
        logic [63:0] regs;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_err = 0;
    int    wptr;

    logic [7:0] m_acc, m_pc;
    logic       m_cy;
    logic [7:0] m_r [8];

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_regs();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_r[i];
        return v;
    endfunction

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = 8'h00;
        wptr = 0;
    endtask

    task automatic put(logic [7:0] b);
        rom[wptr] = b;
        wptr++;
    endtask

    // Reference ISA model from the requirements
    task automatic model_step(output string tag);
        logic [7:0] op, nx;
        logic [8:0] s;
        op = rom[m_pc];
        nx = rom[8'(m_pc + 8'd1)];
        if (op == 8'h74) begin
            m_acc = nx; m_pc = m_pc + 8'd2; tag = "R3";
        end else if ((op & 8'hEF) == 8'hC2) begin
            m_acc[nx[2:0]] = op[4]; m_pc = m_pc + 8'd2; tag = "R4";
        end else if (op == 8'h80) begin
            m_pc = m_pc + 8'd2 + nx; tag = "R9";
        end else if (op[7:3] == 5'b11111) begin
            m_r[op[2:0]] = m_acc; m_pc = m_pc + 8'd1; tag = "R6";
        end else if (op[7:3] == 5'b00111) begin
            s = {1'b0, m_acc} + {1'b0, m_r[op[2:0]]} + {8'd0, m_cy};
            m_acc = s[7:0]; m_cy = s[8]; m_pc = m_pc + 8'd1; tag = "R7";
        end else if (op == 8'hC4) begin
            m_acc = {m_acc[3:0], m_acc[7:4]}; m_pc = m_pc + 8'd1; tag = "R8";
        end else begin
            m_pc = m_pc + 8'd1; tag = "R5";
        end
    endtask

    task automatic run_prog(int steps);
        item_t it;
        string t;
        rst = 1'b1;
        m_acc = 8'h00; m_pc = 8'h00; m_cy = 1'b0;
        for (int i = 0; i < 8; i++) m_r[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "reset acc", {56'd0, dbg_acc}, 64'd0);
        check("R10", "reset pc", {56'd0, dbg_pc}, 64'd0);
        check("R10", "reset regs", dbg_regs, 64'd0);
        for (int k = 0; k < steps; k++) begin
            model_step(t);
            it.acc = m_acc; it.pc = m_pc; it.regs = model_regs(); it.tag = t;
            sb.push_back(it);
        end
        #1 rst = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: one instruction completes every third clock after reset (R1)
    initial begin
        int cyc = 0;
        item_t it;
        forever begin
            @(negedge clk);
            if (rst) begin
                cyc = 0;
            end else begin
                cyc++;
                if (cyc == 3) begin
                    cyc = 0;
                    if (sb.size() != 0) begin
                        it = sb.pop_front();
                        check(it.tag, "acc R1", {56'd0, dbg_acc}, {56'd0, it.acc});
                        check(it.tag, "pc R11", {56'd0, dbg_pc}, {56'd0, it.pc});
                        check(it.tag, "regs", dbg_regs, it.regs);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R4 clear each bit in turn from 0xFF
        clear_rom();
        put(8'h74); put(8'hFF);
        for (int b = 0; b < 8; b++) begin put(8'hC2); put(8'(b)); end
        put(8'h80); put(8'hFE);
        run_prog(12);
        check("R4", "clear sweep acc", {56'd0, dbg_acc}, 64'h00);
        check("R9", "self jump pc", {56'd0, dbg_pc}, 64'h12);

        // R4 set each bit in turn from 0x00, plus a repeated set
        clear_rom();
        put(8'h74); put(8'h00);
        for (int b = 0; b < 8; b++) begin put(8'hD2); put(8'(b)); end
        put(8'hD2); put(8'h03);
        put(8'h80); put(8'hFE);
        run_prog(12);
        check("R4", "set sweep acc", {56'd0, dbg_acc}, 64'hFF);

        // Mixed program: R6 R7 R8 R4
        clear_rom();
        put(8'h74); put(8'h01); put(8'hF8); put(8'h38); put(8'hD2); put(8'h03);
        put(8'hF9); put(8'hC4); put(8'hC2); put(8'h05); put(8'hFA);
        put(8'h80); put(8'hFE);
        run_prog(10);
        check("R8", "mixed acc", {56'd0, dbg_acc}, 64'h80);
        check("R6", "mixed r0", {56'd0, dbg_regs[7:0]}, 64'h01);
        check("R7", "mixed r1", {56'd0, dbg_regs[15:8]}, 64'h0A);
        check("R6", "mixed r2", {56'd0, dbg_regs[23:16]}, 64'h80);

        // Carry chain, ignored operand bits, unknown opcodes, forward jump
        clear_rom();
        put(8'h74); put(8'hFF); put(8'hF8); put(8'h38);
        put(8'h74); put(8'h00); put(8'h38); put(8'hF9); put(8'h39); put(8'h39);
        put(8'hD2); put(8'hF9); put(8'hE2); put(8'hC3); put(8'hFF);
        put(8'h80); put(8'h02); put(8'h74); put(8'h55);
        put(8'hC4); put(8'h80); put(8'hFE);
        run_prog(16);
        check("R7", "carry chain then swap acc", {56'd0, dbg_acc}, 64'h30);
        check("R5", "r7 after unknown ops", {56'd0, dbg_regs[63:56]}, 64'h03);
        check("R9", "forward jump then self pc", {56'd0, dbg_pc}, 64'h14);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule